// File: doc/BRIEF.md
# Serial Port Data Queues with Level Requests

This block sits between a host register port and the serial transmit and receive engines of an asynchronous serial port. Host writes to the data address are queued for the transmitter, and characters delivered by the receiver are queued, together with their per-character error flags, until the host reads them. The block also keeps the sticky receive error status and clears it on command.

A mode input selects between full queueing (16 entries per direction) and a one-character holding register per direction. From the fill level of each queue the block drives level interrupts, single-transfer DMA requests and burst DMA requests. Burst and interrupt levels are programmed in eighths of the queue depth. An end-of-transmission interrupt tells the host that the transmit queue is empty and the line has gone quiet.

Top module: `uart_queue_hub`

## Requirements
- R1: The transmit queue returns host bytes in the order written, presents the oldest on `tx_byte` with `tx_avail` high, removes it on `tx_take`, holds 16 bytes and drops writes that arrive while it is full.
- R2: Each receive entry is 12 bits: data in bits 7..0, framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11.
- R3: With `fifo_en` low, each direction holds one character; a write or arrival while that character is present is dropped (on the receive side it counts as an overrun).
- R4: A host read of the data address (`host_sel`=0) pops the oldest receive entry, and that entry appears on `host_rdata` from the next cycle. A read of an empty queue pops nothing and repeats the last entry popped (0 after reset).
- R5: A character arriving while the receive queue is full leaves the queue unchanged, sets the status overrun bit in the next cycle, and marks the next character that is stored with its overrun bit.
- R6: A host read of the status address (`host_sel`=1) returns, in bits 3..0 in the entry flag order {overrun, break, parity, framing}, the overrun events plus the OR of the flags of every entry popped since the last clear.
- R7: Any host write to the status address clears all four status bits. An overrun in the same cycle still sets the overrun bit.
- R8: Level select codes 0, 1, 2 and 3 give levels of 2, 4, 8 and 12 entries; codes 4 to 7 give 14.
- R9: `rx_dma_single` is high while the receive queue holds at least one entry. `rx_dma_burst` and `rx_irq` are high while the fill level is at or above the receive level (1 in holding mode).
- R10: `tx_dma_single` is high while a transmit slot is free. `tx_dma_burst` is high while the free slots number at least the transmit level (1 in holding mode). `tx_irq` is high while the fill level is at or below the transmit level (0 in holding mode).
- R11: `eot_irq` is high exactly when the transmit queue is empty and `tx_idle` is high.
- R12: Reset clears both queues, the status, the pending overrun mark, the last-read value and `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1: 16-entry queues, 0: one-character holding registers |
| tx_lvl_sel | input | 3 | Transmit level code |
| rx_lvl_sel | input | 3 | Receive level code |
| host_sel | input | 1 | 0: data address, 1: status/clear address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 12 | Registered host read data |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_avail | output | 1 | Transmit queue is not empty |
| tx_take | input | 1 | Transmitter takes the oldest byte |
| tx_idle | input | 1 | Transmitter has finished shifting |
| rx_byte | input | 8 | Received character |
| rx_frm_err | input | 1 | Stop bit was missing |
| rx_par_err | input | 1 | Parity mismatch |
| rx_brk | input | 1 | Line held low for a full frame |
| rx_strobe | input | 1 | Receiver delivers a character |
| tx_irq | output | 1 | Transmit level interrupt |
| rx_irq | output | 1 | Receive level interrupt |
| eot_irq | output | 1 | End-of-transmission interrupt |
| tx_dma_single | output | 1 | Transmit single request |
| tx_dma_burst | output | 1 | Transmit burst request |
| rx_dma_single | output | 1 | Receive single request |
| rx_dma_burst | output | 1 | Receive burst request |

## Verification
The assertions take for granted that `fifo_en` changes only while both queues are empty, because a switch to holding mode with several entries queued would leave more than one character behind a capacity of one. They also take for granted that the host issues a single access per strobe with a stable `host_sel`. The stimulus drains both queues before each mode change. Data and status accesses share one select line, so a pop and a clear can never fall in the same cycle, while arrivals and transmitter takes are driven freely against host traffic.

// File: rtl/uq_pkg.sv
// Package: shared widths, flag layout and level decoding for the
// serial port queue block. Assumes an 8-bit character and 4 flags.
package uq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned FLAG_W = 4;
    localparam int unsigned RX_W   = DATA_W + FLAG_W;

    // Per-character error flags, MSB first as stored in entry bits 11..8.
    typedef struct packed {
        logic ovr;
        logic brk;
        logic par;
        logic frm;
    } uq_flags_t;

    // Host address decode.
    typedef enum logic {
        UQ_ADDR_DATA = 1'b0,
        UQ_ADDR_STAT = 1'b1
    } uq_addr_e;

    // Level in entries for a select code, in eighths of the depth.
    function automatic int unsigned uq_level(input logic [2:0] sel, input int unsigned depth);
        case (sel)
            3'd0:    return depth / 8;
            3'd1:    return depth / 4;
            3'd2:    return depth / 2;
            3'd3:    return (depth * 3) / 4;
            default: return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/uq_queue.sv
// Module: uq_queue
// Circular queue of WIDTH-bit entries with a one-entry mode that uses only
// slot 0. Pushes while full and pops while empty are ignored.
// Assumes one_deep only changes while the queue is empty.
module uq_queue #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             one_deep,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr, wr_idx, rd_idx;
    logic [CNT_W-1:0] cap;
    logic             push_ok, pop_ok;

    // Capacity, accept decisions and slot selection.
    always_comb begin
        cap     = one_deep ? CNT_W'(1) : CNT_W'(DEPTH);
        full    = (count >= cap);
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        wr_idx  = one_deep ? '0 : wptr;
        rd_idx  = one_deep ? '0 : rptr;
    end

    assign dout = mem[rd_idx];

    // Entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (push_ok) begin
            mem[wr_idx] <= din;
        end
    end

    // Pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (one_deep) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
                if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

endmodule

// File: rtl/uq_levels.sv
// Module: uq_levels
// Turns a queue fill count into single, burst and level-interrupt requests.
// TX_SIDE selects free-space semantics (transmit) or fill semantics (receive).
// Assumes count never exceeds the current capacity.
module uq_levels #(
    parameter int unsigned DEPTH   = 16,
    parameter bit          TX_SIDE = 1'b0,
    parameter int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             one_deep,
    input  logic [2:0]       sel,
    input  logic [CNT_W-1:0] count,
    output logic             single_req,
    output logic             burst_req,
    output logic             level_irq
);

    import uq_pkg::*;

    logic [CNT_W-1:0] lvl, thr;

    // Programmed level and the level actually applied in this mode.
    always_comb begin
        lvl = CNT_W'(uq_level(sel, DEPTH));
        thr = one_deep ? CNT_W'(1) : lvl;
    end

    if (TX_SIDE) begin : g_tx
        logic [CNT_W-1:0] cap, room;
        // Free slots left in the queue.
        always_comb begin
            cap  = one_deep ? CNT_W'(1) : CNT_W'(DEPTH);
            room = (count >= cap) ? '0 : cap - count;
        end
        assign single_req = (room != '0);
        assign burst_req  = (room >= thr);
        assign level_irq  = (count <= (one_deep ? '0 : lvl));
    end else begin : g_rx
        assign single_req = (count != '0);
        assign burst_req  = (count >= thr);
        assign level_irq  = burst_req;
    end

endmodule

// File: rtl/uq_rx_status.sv
// Module: uq_rx_status
// Sticky receive error status plus the pending overrun mark that tags the
// next stored character. Clear is applied before new events in a cycle.
module uq_rx_status (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovr_evt,
    input  logic              store,
    input  logic              pop_ok,
    input  uq_pkg::uq_flags_t popped,
    input  logic              clear,
    output uq_pkg::uq_flags_t flags,
    output logic              pend_ovr
);

    import uq_pkg::*;

    uq_flags_t nxt;

    // Next status: clear, then popped flags, then a fresh overrun.
    always_comb begin
        nxt = clear ? '0 : flags;
        if (pop_ok)  nxt = nxt | popped;
        if (ovr_evt) nxt.ovr = 1'b1;
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= nxt;
    end

    // Overrun mark carried to the next character that is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_ovr <= 1'b0;
        else if (ovr_evt) pend_ovr <= 1'b1;
        else if (store)   pend_ovr <= 1'b0;
    end

endmodule

// File: rtl/uart_queue_hub.sv
// Module: uart_queue_hub (top)
// Transmit and receive queues between a strobe-based host port and the
// serial engines, with level interrupts, DMA requests and error status.
// Assumes fifo_en changes only while both queues are empty.
module uart_queue_hub #(
    parameter int unsigned DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fifo_en,
    input  logic [2:0]             tx_lvl_sel,
    input  logic [2:0]             rx_lvl_sel,
    input  logic                   host_sel,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [7:0]             host_wdata,
    output logic [11:0]            host_rdata,
    output logic [7:0]             tx_byte,
    output logic                   tx_avail,
    input  logic                   tx_take,
    input  logic                   tx_idle,
    input  logic [7:0]             rx_byte,
    input  logic                   rx_frm_err,
    input  logic                   rx_par_err,
    input  logic                   rx_brk,
    input  logic                   rx_strobe,
    output logic                   tx_irq,
    output logic                   rx_irq,
    output logic                   eot_irq,
    output logic                   tx_dma_single,
    output logic                   tx_dma_burst,
    output logic                   rx_dma_single,
    output logic                   rx_dma_burst
);

    import uq_pkg::*;

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             one_deep;
    logic             tx_push, tx_full, tx_empty;
    logic [CNT_W-1:0] tx_count;
    logic             rx_pop, rx_full, rx_empty, rx_store, ovr_evt, st_clear;
    logic [CNT_W-1:0] rx_count;
    logic [RX_W-1:0]  rx_din, rx_head, last_rx;
    uq_flags_t        st_flags;
    logic             pend_ovr;

    // Host strobe decode and receive-side events.
    always_comb begin
        one_deep = !fifo_en;
        tx_push  = host_wr && (host_sel == UQ_ADDR_DATA);
        st_clear = host_wr && (host_sel == UQ_ADDR_STAT);
        rx_pop   = host_rd && (host_sel == UQ_ADDR_DATA);
        ovr_evt  = rx_strobe && rx_full;
        rx_store = rx_strobe && !rx_full;
        rx_din   = {pend_ovr, rx_brk, rx_par_err, rx_frm_err, rx_byte};
    end

    uq_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .one_deep(one_deep),
        .push(tx_push), .pop(tx_take), .din(host_wdata),
        .dout(tx_byte), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    uq_queue #(.WIDTH(RX_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .one_deep(one_deep),
        .push(rx_strobe), .pop(rx_pop), .din(rx_din),
        .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    uq_rx_status u_stat (
        .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .store(rx_store),
        .pop_ok(rx_pop && !rx_empty), .popped(uq_flags_t'(rx_head[RX_W-1:DATA_W])),
        .clear(st_clear), .flags(st_flags), .pend_ovr(pend_ovr)
    );

    uq_levels #(.DEPTH(DEPTH), .TX_SIDE(1'b1), .CNT_W(CNT_W)) u_txlv (
        .one_deep(one_deep), .sel(tx_lvl_sel), .count(tx_count),
        .single_req(tx_dma_single), .burst_req(tx_dma_burst), .level_irq(tx_irq)
    );

    uq_levels #(.DEPTH(DEPTH), .TX_SIDE(1'b0), .CNT_W(CNT_W)) u_rxlv (
        .one_deep(one_deep), .sel(rx_lvl_sel), .count(rx_count),
        .single_req(rx_dma_single), .burst_req(rx_dma_burst), .level_irq(rx_irq)
    );

    assign tx_avail = !tx_empty;
    assign eot_irq  = tx_empty && tx_idle;

    // Last entry popped, replayed on reads of an empty queue.
    always_ff @(posedge clk) begin
        if (!rst_n)                   last_rx <= '0;
        else if (rx_pop && !rx_empty) last_rx <= rx_head;
    end

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            if (host_sel == UQ_ADDR_DATA) host_rdata <= rx_empty ? last_rx : rx_head;
            else                          host_rdata <= {{(RX_W-FLAG_W){1'b0}}, st_flags};
        end
    end

endmodule

// File: rtl/uq_checker.sv
// Module: uq_checker
// Temporal properties of uart_queue_hub, attached by bind below.
// Assumes fifo_en changes only while both queues are empty.
module uq_checker #(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             host_sel,
    input logic             host_wr,
    input logic             host_rd,
    input logic             rx_strobe,
    input logic             rx_full,
    input logic             rx_empty,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic [3:0]       st_flags,
    input logic [11:0]      last_rx
);

    logic rd_data;
    assign rd_data = host_rd && !host_sel;

    p_full_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && rx_full && !rd_data |=> $stable(rx_count));

    p_ovr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && rx_full |=> st_flags[3]);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_sel && !(rx_strobe && rx_full) |=> st_flags == 4'b0000);

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && rx_empty |=> $stable(last_rx));

    p_pop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && !rx_empty && !rx_strobe |=> rx_count == $past(rx_count) - 1'b1);

    p_hold_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en && $past(!fifo_en) |-> (tx_count <= 1) && (rx_count <= 1));

endmodule

bind uart_queue_hub uq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .host_sel(host_sel),
    .host_wr(host_wr), .host_rd(host_rd), .rx_strobe(rx_strobe),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_count(rx_count),
    .tx_count(tx_count), .st_flags(st_flags), .last_rx(last_rx)
);

// File: tb/sim_uart_queue_hub.sv
// Bench: behavioural queue model compared with the design after every edge.
module sim_uart_queue_hub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b1;
    logic [2:0]  tx_lvl_sel = 3'd2, rx_lvl_sel = 3'd2;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [11:0] host_rdata;
    logic [7:0]  tx_byte;
    logic        tx_avail, tx_take = 1'b0, tx_idle = 1'b1;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_frm_err = 1'b0, rx_par_err = 1'b0, rx_brk = 1'b0, rx_strobe = 1'b0;
    logic        tx_irq, rx_irq, eot_irq;
    logic        tx_dma_single, tx_dma_burst, rx_dma_single, rx_dma_burst;

    int total = 0;
    int bad = 0;
    string phase = "R12";

    logic [7:0]  txq[$];
    logic [11:0] rxq[$];
    logic [3:0]  m_st = '0;
    logic        m_pend = 1'b0;
    logic [11:0] m_last = '0, m_rdata = '0;

    always #4 clk = ~clk;

    uart_queue_hub u0 (.*);

    function automatic int lvl(input logic [2:0] s);
        case (s)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            default: return 14;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model update at each edge, then comparison once outputs settle.
    always @(posedge clk) begin : upd
        int tsz, rsz, tcap, rcap;
        logic [11:0] e;
        logic ovr, popped;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_st = '0; m_pend = 1'b0; m_last = '0; m_rdata = '0;
        end else begin
            tsz = txq.size(); rsz = rxq.size();
            tcap = fifo_en ? 16 : 1; rcap = tcap;
            popped = 1'b0; e = '0;
            if (host_rd) begin
                if (!host_sel) begin
                    if (rsz > 0) begin e = rxq[0]; popped = 1'b1; m_last = e; m_rdata = e; end
                    else m_rdata = m_last;
                end else m_rdata = {8'h00, m_st};
            end
            if (host_wr && host_sel) m_st = '0;
            if (popped) begin m_st = m_st | e[11:8]; void'(rxq.pop_front()); end
            ovr = rx_strobe && (rsz >= rcap);
            if (ovr) m_st[3] = 1'b1;
            if (rx_strobe && rsz < rcap) begin
                rxq.push_back({m_pend, rx_brk, rx_par_err, rx_frm_err, rx_byte});
                m_pend = 1'b0;
            end
            if (ovr) m_pend = 1'b1;
            if (tx_take && tsz > 0) void'(txq.pop_front());
            if (host_wr && !host_sel && tsz < tcap) txq.push_back(host_wdata);
        end
        #2;
        if (rst_n) begin
            tsz = txq.size(); rsz = rxq.size(); tcap = fifo_en ? 16 : 1;
            chk("R1", "tx_avail", tx_avail, tsz > 0);
            if (tsz > 0) chk("R1", "tx_byte", tx_byte, txq[0]);
            chk({"R10/", phase}, "tx_dma_single", tx_dma_single, tsz < tcap);
            chk({"R10/", phase}, "tx_dma_burst", tx_dma_burst, (tcap - tsz) >= (fifo_en ? lvl(tx_lvl_sel) : 1));
            chk({"R10/", phase}, "tx_irq", tx_irq, tsz <= (fifo_en ? lvl(tx_lvl_sel) : 0));
            chk({"R9/", phase}, "rx_dma_single", rx_dma_single, rsz > 0);
            chk({"R9/", phase}, "rx_dma_burst", rx_dma_burst, rsz >= (fifo_en ? lvl(rx_lvl_sel) : 1));
            chk({"R9/", phase}, "rx_irq", rx_irq, rsz >= (fifo_en ? lvl(rx_lvl_sel) : 1));
            chk("R11", "eot_irq", eot_irq, (tsz == 0) && tx_idle);
            chk(phase, "host_rdata", host_rdata, m_rdata);
        end
    end

    task automatic tick();
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; tx_take = 1'b0; rx_strobe = 1'b0;
    endtask

    task automatic hwrite(input logic s, input logic [7:0] d);
        host_sel = s; host_wdata = d; host_wr = 1'b1; tick();
    endtask

    task automatic hread(input logic s);
        host_sel = s; host_rd = 1'b1; tick();
    endtask

    task automatic rxin(input logic [7:0] b, input logic [2:0] f);
        rx_byte = b; {rx_brk, rx_par_err, rx_frm_err} = f; rx_strobe = 1'b1; tick();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state seen at the ports.
        chk("R12", "tx_avail", tx_avail, 0);
        chk("R12", "rx_dma_single", rx_dma_single, 0);
        chk("R12", "tx_dma_single", tx_dma_single, 1);
        chk("R12", "host_rdata", host_rdata, 0);
        hread(1'b1);

        // R1, R8: fill the transmit queue past full, sweep its level code.
        phase = "R1"; tx_idle = 1'b0;
        for (int i = 0; i < 18; i++) begin
            tx_lvl_sel = 3'(i % 8);
            hwrite(1'b0, 8'(i * 7 + 3));
        end
        phase = "R8";
        for (int i = 0; i < 8; i++) begin tx_lvl_sel = 3'(i); tick(); end
        phase = "R10";
        for (int i = 0; i < 20; i++) begin tx_lvl_sel = 3'(i % 5); tx_take = 1'b1; tick(); end
        tx_idle = 1'b1; tick();

        // R5: overfill the receive queue, sweeping the receive level.
        phase = "R5";
        for (int i = 0; i < 18; i++) begin
            rx_lvl_sel = 3'(i % 8);
            rxin(8'(8'h40 + i), 3'(i % 8));
        end
        phase = "R6"; hread(1'b1);
        phase = "R2";
        for (int i = 0; i < 16; i++) begin rx_lvl_sel = 3'(7 - i % 8); hread(1'b0); end
        phase = "R6"; hread(1'b1);
        phase = "R4"; hread(1'b0); hread(1'b0);
        phase = "R5"; rxin(8'h77, 3'b000); hread(1'b0);
        phase = "R7"; hwrite(1'b1, 8'h00); hread(1'b1);
        for (int i = 0; i < 16; i++) rxin(8'(i), 3'b000);
        host_sel = 1'b1; host_wr = 1'b1; rx_byte = 8'hEE; rx_strobe = 1'b1; tick();
        hread(1'b1);
        phase = "R4";
        for (int i = 0; i < 17; i++) hread(1'b0);

        // Mixed transmit traffic with takes and writes in the same cycles.
        phase = "R10";
        for (int i = 0; i < 60; i++) begin
            host_sel = 1'b0; host_wdata = 8'(i); host_wr = (i % 3 != 2);
            tx_take = (i % 2 == 0); tx_idle = (i % 4 == 0); tx_lvl_sel = 3'(i % 5);
            tick();
        end
        for (int i = 0; i < 20; i++) begin tx_take = 1'b1; tick(); end
        tx_idle = 1'b1;

        // R3: holding-register mode on both sides.
        fifo_en = 1'b0; phase = "R3";
        hwrite(1'b0, 8'hA1); hwrite(1'b0, 8'hA2);
        tx_take = 1'b1; tick(); tick();
        rxin(8'h5A, 3'b010); rxin(8'h5B, 3'b000);
        hread(1'b0); hread(1'b1); hwrite(1'b1, 8'h00);
        rxin(8'h5C, 3'b001); hread(1'b0); hread(1'b0); hread(1'b1);
        repeat (3) tick();
        finish_run();
    end

endmodule